// File: doc/BRIEF.md
# Microcontroller Power-State Sequencer

This block sets the power state of a small microcontroller. It watches a strobe from the CPU that marks a sleep instruction, a control bit that chooses between a light and a deep stop, an active-low standby pin, a medium-speed enable with a divisor choice, one stop bit per peripheral module, and bus requests from DMA-style bus masters. From these it drives the CPU halt, the main clock enable, a medium-speed clock-enable pulse, a reset to the supporting modules, a hold for the I/O ports, one clock gate per module and a one-hot bus grant.

A sleep instruction halts the CPU. If the control bit is clear, the clocks keep running. If the bit is set, the clocks stop as well and the port outputs freeze. The light stop resumes on any enabled interrupt. The deep stop resumes only on an external interrupt, and only after a clock-settling count loaded from an input. The standby pin overrides every other condition. While it is low, the clocks stop and the peripherals are held in reset. When it returns high, a fixed reset sequence runs before the CPU starts again. A bus request is granted only between CPU bus cycles. The CPU stays halted until the granted master lets the bus go.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With `sleep_req` high in the running state and `sw_standby_en` low, the next cycle shows `cpu_halt`=1 while `clk_en` stays 1.
- R2: With `sleep_req` high in the running state and `sw_standby_en` high, the next cycle shows `cpu_halt`=1, `clk_en`=0, `med_tick`=0 and every `mod_clk_en` bit 0.
- R3: `port_hold` is 1 in the deep stop and during its clock settling, and 0 in every other state.
- R4: A low `hw_standby_n`, sampled at any clock edge in any state, gives `periph_rst`=1, `cpu_halt`=1, `clk_en`=0 and `bus_gnt`=0 on the next cycle.
- R5: After `hw_standby_n` returns high, `periph_rst`=1, `clk_en`=1 and `cpu_halt`=1 hold for exactly RST_LEN cycles. The block then runs with `periph_rst`=0.
- R6: The light stop ends one cycle after `irq_any` is high. The deep stop ignores `irq_any` and reacts only to `ext_irq`.
- R7: On `ext_irq` in the deep stop, `settle_cnt` is sampled. `clk_en` stays 0 for settle_cnt+1 further cycles, and then the CPU runs.
- R8: With `med_en` low, `med_tick` equals `clk_en`. With `med_en` high, `med_tick` pulses once every N clocked cycles, where N = 2 shifted left by min(`med_div_sel`,4): select values 0..4 give 2, 4, 8, 16, 32, and 5..7 give 32.
- R9: A change of `med_div_sel` while `med_en` is high takes effect only after the next `med_tick` pulse.
- R10: `mod_clk_en[i]` = `clk_en` AND NOT `mod_stop[i]`. The stop bits never change `cpu_halt`.
- R11: In the running state, with any `bus_req` bit set and `cpu_bus_busy` low, the next cycle grants the lowest-index requester as a one-hot `bus_gnt` and sets `cpu_halt`=1. The grant holds until that requester drops its line, and the CPU runs on the cycle after. No grant starts while `cpu_bus_busy` is high.
- R12: After reset the block runs with `cpu_halt`=0, `clk_en`=1, `periph_rst`=0 and no grant. A sleep strobe wins over a bus request in the same cycle. No grant is ever issued in either standby state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle strobe from the CPU for a sleep instruction |
| sw_standby_en | input | 1 | Chooses deep stop (1) or light stop (0) on sleep |
| hw_standby_n | input | 1 | Active-low standby pin |
| irq_any | input | 1 | Any enabled interrupt pending |
| ext_irq | input | 1 | External interrupt pending |
| settle_cnt | input | SETTLE_W | Clock-settling length for deep-stop wake-up |
| med_en | input | 1 | Medium-speed enable |
| med_div_sel | input | 3 | Divisor select for medium speed |
| mod_stop | input | NUM_MODULES | Per-module stop bits |
| bus_req | input | NUM_MASTERS | Bus requests from non-CPU masters |
| cpu_bus_busy | input | 1 | CPU is inside a bus cycle |
| cpu_halt | output | 1 | CPU halted |
| clk_en | output | 1 | Main clock enable |
| med_tick | output | 1 | Clock-enable pulse for CPU and bus masters |
| periph_rst | output | 1 | Reset for the supporting modules |
| port_hold | output | 1 | Freeze I/O port outputs |
| mod_clk_en | output | NUM_MODULES | Per-module clock gates |
| bus_gnt | output | NUM_MASTERS | One-hot bus grant |

## Verification
The bench builds the block with three bus masters, four modules, a 4-bit settle count and RST_LEN of 3. Three masters put the lowest-index choice within reach of a test, with requesters above and below the winner. A 4-bit settle count lets both the zero-length settling and the full 15-count settling run in a short test. The short reset sequence gives many pin-driven standby entries and exits during the random phase, and that phase also covers every divisor from 2 up to 32.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NUM_MODULES = 4,
  parameter int NUM_MASTERS = 2,
  parameter int SETTLE_W    = 8,
  parameter int RST_LEN     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sleep_req,
  input  logic                   sw_standby_en,
  input  logic                   hw_standby_n,
  input  logic                   irq_any,
  input  logic                   ext_irq,
  input  logic [SETTLE_W-1:0]    settle_cnt,
  input  logic                   med_en,
  input  logic [2:0]             med_div_sel,
  input  logic [NUM_MODULES-1:0] mod_stop,
  input  logic [NUM_MASTERS-1:0] bus_req,
  input  logic                   cpu_bus_busy,
  output logic                   cpu_halt,
  output logic                   clk_en,
  output logic                   med_tick,
  output logic                   periph_rst,
  output logic                   port_hold,
  output logic [NUM_MODULES-1:0] mod_clk_en,
  output logic [NUM_MASTERS-1:0] bus_gnt
);
  localparam int RW = $clog2(RST_LEN + 1);

  typedef enum logic [2:0] {
    S_RUN, S_SLEEP, S_DEEP, S_SETTLE, S_HWSTBY, S_HWRST, S_BUSREL
  } st_t;

  st_t st, st_nx;
  logic [SETTLE_W-1:0]    settle_q;
  logic [RW-1:0]          rst_q;
  logic [NUM_MASTERS-1:0] gnt_q, pick;
  logic [5:0]             div_q, div_n, sel_n;

  assign sel_n = (med_div_sel >= 3'd4) ? 6'd32 : (6'd2 << med_div_sel);
  assign pick  = bus_req & (~bus_req + NUM_MASTERS'(1));

  always_comb begin
    st_nx = st;
    if (!hw_standby_n) st_nx = S_HWSTBY;
    else begin
      unique case (st)
        S_RUN:
          if (sleep_req) st_nx = sw_standby_en ? S_DEEP : S_SLEEP;
          else if (|bus_req && !cpu_bus_busy) st_nx = S_BUSREL;
        S_SLEEP:  if (irq_any) st_nx = S_RUN;
        S_DEEP:   if (ext_irq) st_nx = S_SETTLE;
        S_SETTLE: if (settle_q == '0) st_nx = S_RUN;
        S_HWSTBY: st_nx = S_HWRST;
        S_HWRST:  if (rst_q == '0) st_nx = S_RUN;
        S_BUSREL: if (!(|(bus_req & gnt_q))) st_nx = S_RUN;
        default:  st_nx = S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      settle_q <= '0;
      rst_q    <= '0;
      gnt_q    <= '0;
    end else begin
      st <= st_nx;
      if (st == S_DEEP && st_nx == S_SETTLE) settle_q <= settle_cnt;
      else if (st == S_SETTLE && settle_q != '0) settle_q <= settle_q - 1'b1;
      if (st == S_HWSTBY && st_nx == S_HWRST) rst_q <= RW'(RST_LEN - 1);
      else if (st == S_HWRST && rst_q != '0) rst_q <= rst_q - 1'b1;
      if (st == S_RUN && st_nx == S_BUSREL) gnt_q <= pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      div_n <= 6'd2;
    end else if (!med_en) begin
      div_q <= '0;
      div_n <= sel_n;
    end else if (clk_en) begin
      if (div_q == div_n - 6'd1) begin
        div_q <= '0;
        div_n <= sel_n;
      end else div_q <= div_q + 6'd1;
    end
  end

  assign cpu_halt   = (st != S_RUN);
  assign clk_en     = st inside {S_RUN, S_SLEEP, S_BUSREL, S_HWRST};
  assign periph_rst = st inside {S_HWSTBY, S_HWRST};
  assign port_hold  = st inside {S_DEEP, S_SETTLE};
  assign med_tick   = clk_en && (!med_en || div_q == div_n - 6'd1);
  assign mod_clk_en = {NUM_MODULES{clk_en}} & ~mod_stop;
  assign bus_gnt    = (st == S_BUSREL) ? gnt_q : '0;

  p_light_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_req && !sw_standby_en && hw_standby_n) |=> (cpu_halt && clk_en));
  p_deep_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_req && sw_standby_en && hw_standby_n) |=> (port_hold && !clk_en && mod_clk_en == '0));
  p_pin_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_standby_n |=> (periph_rst && !clk_en && bus_gnt == '0));
  p_deep_ignores_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEEP && !ext_irq && hw_standby_n) |=> port_hold);
  p_div_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(med_en) && div_n != $past(div_n)) |-> $past(med_tick));
  p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));
  p_grant_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSREL && $past(st) != S_BUSREL) |-> $past(!cpu_bus_busy && !sleep_req));
  p_no_grant_stby_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hold || periph_rst) |-> bus_gnt == '0);
endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int NM = 4, NB = 3, SW = 4, RL = 3;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, sw_standby_en = 0, hw_standby_n = 1, irq_any = 0, ext_irq = 0;
  logic [SW-1:0] settle_cnt = '0;
  logic med_en = 0;
  logic [2:0] med_div_sel = '0;
  logic [NM-1:0] mod_stop = '0;
  logic [NB-1:0] bus_req = '0;
  logic cpu_bus_busy = 0;
  logic cpu_halt, clk_en, med_tick, periph_rst, port_hold;
  logic [NM-1:0] mod_clk_en;
  logic [NB-1:0] bus_gnt;

  pwr_mode_ctrl #(.NUM_MODULES(NM), .NUM_MASTERS(NB), .SETTLE_W(SW), .RST_LEN(RL)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sw_standby_en(sw_standby_en),
    .hw_standby_n(hw_standby_n), .irq_any(irq_any), .ext_irq(ext_irq),
    .settle_cnt(settle_cnt), .med_en(med_en), .med_div_sel(med_div_sel),
    .mod_stop(mod_stop), .bus_req(bus_req), .cpu_bus_busy(cpu_bus_busy),
    .cpu_halt(cpu_halt), .clk_en(clk_en), .med_tick(med_tick), .periph_rst(periph_rst),
    .port_hold(port_hold), .mod_clk_en(mod_clk_en), .bus_gnt(bus_gnt));

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  string phase = "R12";

  // reference model: 0 run, 1 light stop, 2 deep stop, 3 settling, 4 pin standby, 5 reset sequence, 6 bus released
  int ms = 0, scnt = 0, rcnt = 0, gidx = 0, dcnt = 0, dn = 2;

  function automatic int divisor(input logic [2:0] s);
    return (s >= 4) ? 32 : (2 << s);
  endfunction
  function automatic bit m_clk();
    return ms == 0 || ms == 1 || ms == 5 || ms == 6;
  endfunction

  task automatic model_step();
    int nm;
    if (!rst_n) begin
      ms = 0; scnt = 0; rcnt = 0; gidx = 0; dcnt = 0; dn = 2;
      return;
    end
    if (!med_en) begin dcnt = 0; dn = divisor(med_div_sel); end
    else if (m_clk()) begin
      if (dcnt == dn - 1) begin dcnt = 0; dn = divisor(med_div_sel); end
      else dcnt++;
    end
    nm = ms;
    if (!hw_standby_n) nm = 4;
    else case (ms)
      0: if (sleep_req) nm = sw_standby_en ? 2 : 1;
         else if (bus_req != 0 && !cpu_bus_busy) begin
           nm = 6;
           for (int i = NB - 1; i >= 0; i--) if (bus_req[i]) gidx = i;
         end
      1: if (irq_any) nm = 0;
      2: if (ext_irq) begin nm = 3; scnt = settle_cnt; end
      3: if (scnt == 0) nm = 0; else scnt--;
      4: begin nm = 5; rcnt = RL - 1; end
      5: if (rcnt == 0) nm = 0; else rcnt--;
      6: if (!bus_req[gidx]) nm = 0;
      default: nm = 0;
    endcase
    ms = nm;
  endtask

  task automatic chk(input string rq, input string sig, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [phase %s] %s act=%0d exp=%0d t=%0t", rq, phase, sig, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ck;
    int g;
    ck = m_clk();
    g = (ms == 6) ? (1 << gidx) : 0;
    chk("R1", "cpu_halt", cpu_halt, ms != 0);
    chk("R2", "clk_en", clk_en, ck);
    chk("R3", "port_hold", port_hold, ms == 2 || ms == 3);
    chk("R4", "periph_rst", periph_rst, ms == 4 || ms == 5);
    chk("R8", "med_tick", med_tick, ck && (!med_en || dcnt == dn - 1));
    chk("R10", "mod_clk_en", mod_clk_en, ck ? int'(~mod_stop) & ((1 << NM) - 1) : 0);
    chk("R11", "bus_gnt", bus_gnt, g);
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  initial begin
    @(negedge clk);
    phase = "R12"; cyc(3);                     // reset state
    rst_n = 1; cyc(2);
    phase = "R8"; med_en = 1; med_div_sel = 0; cyc(10);
    med_div_sel = 2; phase = "R9"; cyc(20);    // divisor change waits for a tick
    med_div_sel = 4; cyc(70);
    med_div_sel = 7; cyc(70);
    med_div_sel = 1; cyc(3);
    med_en = 0; phase = "R8"; cyc(4);
    phase = "R10"; mod_stop = 4'b0101; cyc(3);
    phase = "R1"; pulse(sleep_req); cyc(5);
    phase = "R6"; pulse(irq_any); cyc(3);
    phase = "R2"; sw_standby_en = 1; pulse(sleep_req); cyc(4);
    phase = "R6"; irq_any = 1; cyc(4); irq_any = 0;
    phase = "R7"; settle_cnt = 5; pulse(ext_irq); cyc(10);
    pulse(sleep_req); cyc(2); settle_cnt = 0; pulse(ext_irq); cyc(4);
    pulse(sleep_req); cyc(2); settle_cnt = 15; pulse(ext_irq); cyc(20);
    phase = "R11"; mod_stop = 0; cpu_bus_busy = 1; bus_req = 3'b110; cyc(4);
    cpu_bus_busy = 0; cyc(3);
    bus_req = 3'b100; cyc(4);
    bus_req = 3'b111; cyc(3);
    bus_req = 3'b110; cyc(3);
    bus_req = 0; cyc(3);
    phase = "R12"; sw_standby_en = 0; bus_req = 3'b001; pulse(sleep_req); cyc(4);
    irq_any = 1; cyc(1); irq_any = 0; cyc(3); bus_req = 0; cyc(2);
    sw_standby_en = 1; pulse(sleep_req); bus_req = 3'b011; cyc(5); bus_req = 0; cyc(1);
    pulse(ext_irq); cyc(3);
    phase = "R4"; bus_req = 3'b010; cyc(2); hw_standby_n = 0; cyc(4);
    phase = "R5"; bus_req = 0; hw_standby_n = 1; cyc(6);
    phase = "R4"; sw_standby_en = 0; pulse(sleep_req); cyc(2); hw_standby_n = 0; cyc(2);
    hw_standby_n = 1; cyc(1); hw_standby_n = 0; cyc(2);
    phase = "R5"; hw_standby_n = 1; cyc(6);
    phase = "R4"; sw_standby_en = 1; pulse(sleep_req); cyc(1); settle_cnt = 9; pulse(ext_irq);
    cyc(2); hw_standby_n = 0; cyc(2); hw_standby_n = 1; cyc(5);
    phase = "R12"; sw_standby_en = 0; pulse(sleep_req); cyc(2);
    rst_n = 0; cyc(2); rst_n = 1; cyc(3);
    phase = "R8";                                // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      sleep_req     = ($urandom % 16) == 0;
      sw_standby_en = $urandom % 2;
      hw_standby_n  = ($urandom % 80) != 0;
      irq_any       = ($urandom % 8) == 0;
      ext_irq       = ($urandom % 24) == 0;
      settle_cnt    = SW'($urandom);
      if (($urandom % 32) == 0) med_en = ~med_en;
      if (($urandom % 16) == 0) med_div_sel = 3'($urandom);
      mod_stop      = NM'($urandom);
      if (($urandom % 4) == 0) bus_req = NB'($urandom);
      cpu_bus_busy  = ($urandom % 3) == 0;
      cyc(1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule